// File: doc/BRIEF.md
# Banded Matrix Powers Engine

This block produces the chain of vectors A·x, A²·x, up to Aᵏ·x for a square banded matrix whose diagonals are held on chip. An array of processing elements shares the rows: each element owns an equal, contiguous slice of rows, holds that slice's diagonals, and walks its rows in lockstep with the others. Every element computes one full row per cycle through a multiply stage and a summing stage. The matrix and the start vector are loaded once. All k products then run back to back with no reload between them.

Between levels, every element passes the results of its outermost rows to its left and right neighbours through small FIFOs. The neighbours need exactly those values for their next level. Each row is computed once per level, so a large k costs no repeated work. Two vector banks alternate per element, so each level reads only the finished values of the previous level. Every level's result is kept in an on-chip store and can be read back by level and row once the run completes.

Top module: `band_power_engine`

## Requirements
- R1: With `ld_vec`=0 a load writes the coefficient in row `ld_row`, slot `ld_diag`. Slot d of row i multiplies vector entry i+d−H, where H=(BW−1)/2, so slot H is the main diagonal. With `ld_vec`=1 a load writes entry `ld_row` of the start vector. Loads are accepted only while `busy` is low.
- R2: Level j (1..k) row i equals the sum over slots of coefficient × level j−1 entry, arithmetically shifted right by FRAC bits (rounding toward minus infinity). Level 0 is the loaded start vector. With the default FRAC of 8, the value 256 stands for 1.0.
- R3: A level result above 32767 is stored as 32767, and one below −32768 is stored as −32768.
- R4: Vector entries with an index below 0 or above N−1 count as zero, whatever coefficient is loaded in that slot.
- R5: Rows whose band reaches into a neighbouring element's rows use that neighbour's values from the previous level. This holds at every level up to MAXK.
- R6: After reset `busy` and `done` are low. `busy` is high from the cycle after an accepted `start` until `done`. `done` is high for exactly one cycle, after the last level completes, and `busy` is low in the following cycle.
- R7: A requested k of 0 runs one level, and a k above MAXK runs MAXK levels. Each takes the same number of cycles as an explicit k of 1 or MAXK.
- R8: `start` while `busy` is high is ignored: no extra levels run, the run length does not change, and no second `done` follows.
- R9: `rd_data` shows the stored result of level `rd_level` (1..MAXK), row `rd_row`, without a clock edge. Results stay until a later run overwrites them. A repeated run uses the loaded start vector again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_en | input | 1 | Load strobe |
| ld_vec | input | 1 | 1: start vector load, 0: coefficient load |
| ld_row | input | RW | Row of the load |
| ld_diag | input | DGW | Diagonal slot of a coefficient load |
| ld_data | input | DW | Signed load value |
| start | input | 1 | Begin a run |
| k_in | input | KW | Number of levels requested |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| rd_level | input | KW | Level to read (1..MAXK) |
| rd_row | input | RW | Row to read |
| rd_data | output | DW | Stored result |

## Verification
The bench targets rows next to the element boundaries and at both ends of the matrix. A single-off-diagonal matrix shifts the start vector by one or two places per level, so a halo sent to the wrong side or slot, or an unmasked end row, shows up at once as a misplaced value or a nonzero value past the end. Large values with a gain of 2.0 push sums past both limits, which a design that wraps instead of clamping gets wrong in sign. Run lengths are compared for clamped and explicit k and for a `start` repeated mid-run; a wrong clamp, or a restart, changes the cycle count or produces a second `done`.

// File: rtl/bmp_pkg.sv
package bmp_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_COPY,
      ST_XCHG,
      ST_COMP,
      ST_DONE
   } seq_state_e;

   function automatic int clog2_min1(input int v);
      return (v > 1) ? $clog2(v) : 1;
   endfunction

endpackage

// File: rtl/bmp_halo_fifo.sv
module bmp_halo_fifo #(
   parameter int DW    = 16,
   parameter int DEPTH = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          push,
   input  logic [DW-1:0] din,
   input  logic          pop,
   output logic [DW-1:0] dout,
   output logic          empty
);
   localparam int PW = bmp_pkg::clog2_min1(DEPTH);
   localparam int CW = $clog2(DEPTH + 1);

   logic [DW-1:0] mem [DEPTH];
   logic [PW-1:0] wp, rp;
   logic [CW-1:0] cnt;
   logic          full;

   assign full  = (cnt == CW'(DEPTH));
   assign empty = (cnt == '0);
   assign dout  = mem[rp];

   function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
      return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
   endfunction

   always_ff @(posedge clk) begin
      if (push) mem[wp] <= din;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wp  <= '0;
         rp  <= '0;
         cnt <= '0;
      end else begin
         if (push) wp <= bump(wp);
         if (pop)  rp <= bump(rp);
         case ({push, pop})
            2'b10:   cnt <= cnt + 1'b1;
            2'b01:   cnt <= cnt - 1'b1;
            default: cnt <= cnt;
         endcase
      end
   end

   // R5: halo traffic never exceeds the channel depth
   a_r5_fifo_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      push |-> !full);
   a_r5_fifo_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
      pop |-> !empty);

endmodule

// File: rtl/bmp_seq.sv
module bmp_seq #(
   parameter int ROWS_PE = 4,
   parameter int H       = 2,
   parameter int MAXK    = 8,
   parameter int KW      = 4,
   parameter int RLW     = 2,
   parameter int HW      = 1
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           start,
   input  logic [KW-1:0]  k_in,
   input  logic           all_rx,
   output logic           busy,
   output logic           done,
   output logic           copy,
   output logic           xpush,
   output logic           xstart,
   output logic [HW-1:0]  xsel,
   output logic           comp_vld,
   output logic [RLW-1:0] comp_row,
   output logic [KW-1:0]  lvl
);
   import bmp_pkg::*;

   localparam int CNW = $clog2(ROWS_PE + H + 2);

   seq_state_e     st;
   logic [CNW-1:0] cnt;
   logic [KW-1:0]  keff;
   logic [KW-1:0]  k_clamped;

   always_comb begin
      if (k_in == '0)             k_clamped = KW'(1);
      else if (int'(k_in) > MAXK) k_clamped = KW'(MAXK);
      else                        k_clamped = k_in;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st   <= ST_IDLE;
         cnt  <= '0;
         lvl  <= '0;
         keff <= KW'(1);
      end else begin
         case (st)
            ST_IDLE: if (start) begin
               keff <= k_clamped;
               lvl  <= '0;
               st   <= ST_COPY;
            end
            ST_COPY: begin
               cnt <= '0;
               st  <= ST_XCHG;
            end
            ST_XCHG: begin
               if (cnt >= CNW'(H) && all_rx) begin
                  cnt <= '0;
                  st  <= ST_COMP;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            ST_COMP: begin
               if (cnt == CNW'(ROWS_PE)) begin
                  cnt <= '0;
                  if (lvl + 1'b1 == keff) begin
                     st <= ST_DONE;
                  end else begin
                     lvl <= lvl + 1'b1;
                     st  <= ST_XCHG;
                  end
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            ST_DONE: st <= ST_IDLE;
            default: st <= ST_IDLE;
         endcase
      end
   end

   assign busy     = (st != ST_IDLE);
   assign done     = (st == ST_DONE);
   assign copy     = (st == ST_COPY);
   assign xstart   = (st == ST_XCHG) && (cnt == '0);
   assign xpush    = (st == ST_XCHG) && (cnt < CNW'(H));
   assign xsel     = HW'(cnt);
   assign comp_vld = (st == ST_COMP) && (cnt < CNW'(ROWS_PE));
   assign comp_row = RLW'(cnt);

   // R6: end-of-run pulse lasts one cycle
   a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   // R7: the level being computed never reaches the clamped count
   a_r7_level_below_k: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_COMP) |-> (lvl < keff));
   // R8: the level count is frozen while a run is active
   a_r8_k_held: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> $stable(keff));

endmodule

// File: rtl/bmp_pe.sv
module bmp_pe #(
   parameter int DW      = 16,
   parameter int FRAC    = 8,
   parameter int BW      = 5,
   parameter int H       = 2,
   parameter int ROWS_PE = 4,
   parameter int MAXK    = 8,
   parameter int KW      = 4,
   parameter int RLW     = 2,
   parameter int DGW     = 3,
   parameter int HW      = 1,
   parameter int FIRST   = 0,
   parameter int LAST    = 0
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           band_we,
   input  logic           x_we,
   input  logic [RLW-1:0] ld_row,
   input  logic [DGW-1:0] ld_diag,
   input  logic [DW-1:0]  ld_data,
   input  logic           copy,
   input  logic           xpush,
   input  logic           xstart,
   input  logic [HW-1:0]  xsel,
   input  logic           comp_vld,
   input  logic [RLW-1:0] comp_row,
   input  logic [KW-1:0]  lvl,
   output logic           out_l_push,
   output logic [DW-1:0]  out_l_data,
   output logic           out_r_push,
   output logic [DW-1:0]  out_r_data,
   input  logic           in_l_empty,
   input  logic [DW-1:0]  in_l_data,
   output logic           in_l_pop,
   input  logic           in_r_empty,
   input  logic [DW-1:0]  in_r_data,
   output logic           in_r_pop,
   output logic           rx_done,
   input  logic [KW-1:0]  rd_lvl,
   input  logic [RLW-1:0] rd_row,
   output logic [DW-1:0]  rd_val
);
   localparam int LW  = ROWS_PE + 2 * H;
   localparam int IW  = bmp_pkg::clog2_min1(LW);
   localparam int PWD = 2 * DW;
   localparam int AW  = PWD + $clog2(BW) + 1;
   localparam int HCW = $clog2(H + 1);
   localparam logic signed [AW-1:0] SMAX = {{(AW-DW+1){1'b0}}, {(DW-1){1'b1}}};
   localparam logic signed [AW-1:0] SMIN = {{(AW-DW+1){1'b1}}, {(DW-1){1'b0}}};

   logic signed [DW-1:0]  band_m [ROWS_PE][BW];
   logic signed [DW-1:0]  xs     [ROWS_PE];
   logic signed [DW-1:0]  vb     [2][LW];
   logic signed [DW-1:0]  res_m  [MAXK][ROWS_PE];
   logic signed [DW-1:0]  opnd   [BW];
   logic signed [PWD-1:0] p1     [BW];
   logic                  v1;
   logic [RLW-1:0]        r1;
   logic signed [AW-1:0]  acc, shf;
   logic signed [DW-1:0]  sat_v;
   logic [HCW-1:0]        rx_l_cnt, rx_r_cnt;
   logic                  rb;

   assign rb = lvl[0];

   // coefficient and start-vector storage
   always_ff @(posedge clk) begin
      if (band_we && int'(ld_diag) < BW) band_m[ld_row][ld_diag] <= ld_data;
      if (x_we) xs[ld_row] <= ld_data;
   end

   // halo transmit: outermost own rows of the bank just produced
   assign out_l_push = xpush;
   assign out_r_push = xpush;
   assign out_l_data = vb[rb][IW'(H) + IW'(xsel)];
   assign out_r_data = vb[rb][IW'(ROWS_PE) + IW'(xsel)];

   // halo receive
   assign in_l_pop = !in_l_empty && (rx_l_cnt < HCW'(H)) && !xstart;
   assign in_r_pop = !in_r_empty && (rx_r_cnt < HCW'(H)) && !xstart;
   assign rx_done  = (rx_l_cnt == HCW'(H)) && (rx_r_cnt == HCW'(H)) && !xstart;

   always_ff @(posedge clk) begin
      if (!rst_n || xstart) begin
         rx_l_cnt <= '0;
         rx_r_cnt <= '0;
      end else begin
         if (in_l_pop) rx_l_cnt <= rx_l_cnt + 1'b1;
         if (in_r_pop) rx_r_cnt <= rx_r_cnt + 1'b1;
      end
   end

   // stage 1: one product per diagonal slot, outside-matrix entries masked
   always_comb begin
      for (int d = 0; d < BW; d++) begin
         opnd[d] = vb[rb][IW'(comp_row) + IW'(d)];
         if ((FIRST != 0 && int'(comp_row) + d < H) ||
             (LAST != 0 && int'(comp_row) + d >= H + ROWS_PE))
            opnd[d] = '0;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) v1 <= 1'b0;
      else        v1 <= comp_vld;
      r1 <= comp_row;
      for (int d = 0; d < BW; d++)
         p1[d] <= band_m[comp_row][d] * opnd[d];
   end

   // stage 2: reduction, scaling and clamping
   always_comb begin
      acc = '0;
      for (int d = 0; d < BW; d++)
         acc = acc + AW'(p1[d]);
      shf = acc >>> FRAC;
      if (shf > SMAX)      sat_v = SMAX[DW-1:0];
      else if (shf < SMIN) sat_v = SMIN[DW-1:0];
      else                 sat_v = shf[DW-1:0];
   end

   // ping-pong vector banks
   always_ff @(posedge clk) begin
      if (copy)
         for (int r = 0; r < ROWS_PE; r++) vb[0][H + r] <= xs[r];
      if (in_l_pop) vb[rb][IW'(rx_l_cnt)] <= in_l_data;
      if (in_r_pop) vb[rb][IW'(H + ROWS_PE) + IW'(rx_r_cnt)] <= in_r_data;
      if (v1) vb[!rb][IW'(H) + IW'(r1)] <= sat_v;
   end

   always_ff @(posedge clk) begin
      if (v1) res_m[lvl][r1] <= sat_v;
   end

   always_comb begin
      rd_val = '0;
      if (rd_lvl != '0 && int'(rd_lvl) <= MAXK)
         rd_val = res_m[rd_lvl - KW'(1)][rd_row];
   end

   // R5: each side accepts exactly H halo words per exchange
   a_r5_rx_bounded: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_l_cnt <= HCW'(H)) && (rx_r_cnt <= HCW'(H)));
   // R2: no row result is written while halo words are still arriving
   a_r2_no_write_during_rx: assert property (@(posedge clk) disable iff (!rst_n)
      (in_l_pop || in_r_pop) |-> !v1);

endmodule

// File: rtl/band_power_engine.sv
module band_power_engine #(
   parameter int NPE     = 4,
   parameter int ROWS_PE = 4,
   parameter int BW      = 5,
   parameter int MAXK    = 8,
   parameter int DW      = 16,
   parameter int FRAC    = 8,
   localparam int N      = NPE * ROWS_PE,
   localparam int RW     = bmp_pkg::clog2_min1(N),
   localparam int KW     = $clog2(MAXK + 1),
   localparam int DGW    = bmp_pkg::clog2_min1(BW)
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           ld_en,
   input  logic           ld_vec,
   input  logic [RW-1:0]  ld_row,
   input  logic [DGW-1:0] ld_diag,
   input  logic [DW-1:0]  ld_data,
   input  logic           start,
   input  logic [KW-1:0]  k_in,
   output logic           busy,
   output logic           done,
   input  logic [KW-1:0]  rd_level,
   input  logic [RW-1:0]  rd_row,
   output logic [DW-1:0]  rd_data
);
   localparam int H   = (BW - 1) / 2;
   localparam int RLW = bmp_pkg::clog2_min1(ROWS_PE);
   localparam int HW  = bmp_pkg::clog2_min1(H);
   localparam int PEW = bmp_pkg::clog2_min1(NPE);

   if (BW < 3 || BW % 2 == 0) begin : g_bad_bw
      $error("band width must be odd and at least 3");
   end
   if (ROWS_PE < H) begin : g_bad_rows
      $error("each element needs at least H rows");
   end
   if (NPE < 2) begin : g_bad_npe
      $error("at least two processing elements are required");
   end
   if (MAXK < 1 || FRAC >= 2 * DW) begin : g_bad_misc
      $error("MAXK must be positive and FRAC below the product width");
   end

   logic           copy, xpush, xstart, comp_vld, all_rx;
   logic [HW-1:0]  xsel;
   logic [RLW-1:0] comp_row;
   logic [KW-1:0]  lvl;

   logic [PEW-1:0] ld_pe, rd_pe;
   logic [RLW-1:0] ld_loc, rd_loc;
   logic           ld_ok;

   assign ld_ok  = ld_en && !busy;
   assign ld_pe  = PEW'(int'(ld_row) / ROWS_PE);
   assign ld_loc = RLW'(int'(ld_row) % ROWS_PE);
   assign rd_pe  = PEW'(int'(rd_row) / ROWS_PE);
   assign rd_loc = RLW'(int'(rd_row) % ROWS_PE);

   // ring channels: r_* carries rightward, l_* carries leftward
   logic          r_push [NPE], l_push [NPE];
   logic [DW-1:0] r_din  [NPE], l_din  [NPE];
   logic          r_pop  [NPE], l_pop  [NPE];
   logic [DW-1:0] r_dout [NPE], l_dout [NPE];
   logic          r_empty[NPE], l_empty[NPE];
   logic [NPE-1:0] rx_done;
   logic [DW-1:0]  rd_vals [NPE];

   assign all_rx = &rx_done;

   bmp_seq #(
      .ROWS_PE(ROWS_PE), .H(H), .MAXK(MAXK), .KW(KW), .RLW(RLW), .HW(HW)
   ) seq_i (
      .clk(clk), .rst_n(rst_n), .start(start), .k_in(k_in), .all_rx(all_rx),
      .busy(busy), .done(done), .copy(copy), .xpush(xpush), .xstart(xstart),
      .xsel(xsel), .comp_vld(comp_vld), .comp_row(comp_row), .lvl(lvl)
   );

   for (genvar i = 0; i < NPE; i++) begin : g_pe
      localparam int IL = (i + NPE - 1) % NPE;
      localparam int IR = (i + 1) % NPE;

      bmp_halo_fifo #(.DW(DW), .DEPTH(H)) rfifo_i (
         .clk(clk), .rst_n(rst_n), .push(r_push[i]), .din(r_din[i]),
         .pop(r_pop[i]), .dout(r_dout[i]), .empty(r_empty[i])
      );
      bmp_halo_fifo #(.DW(DW), .DEPTH(H)) lfifo_i (
         .clk(clk), .rst_n(rst_n), .push(l_push[i]), .din(l_din[i]),
         .pop(l_pop[i]), .dout(l_dout[i]), .empty(l_empty[i])
      );

      bmp_pe #(
         .DW(DW), .FRAC(FRAC), .BW(BW), .H(H), .ROWS_PE(ROWS_PE), .MAXK(MAXK),
         .KW(KW), .RLW(RLW), .DGW(DGW), .HW(HW),
         .FIRST(i == 0 ? 1 : 0), .LAST(i == NPE - 1 ? 1 : 0)
      ) pe_i (
         .clk(clk), .rst_n(rst_n),
         .band_we(ld_ok && !ld_vec && ld_pe == PEW'(i)),
         .x_we(ld_ok && ld_vec && ld_pe == PEW'(i)),
         .ld_row(ld_loc), .ld_diag(ld_diag), .ld_data(ld_data),
         .copy(copy), .xpush(xpush), .xstart(xstart), .xsel(xsel),
         .comp_vld(comp_vld), .comp_row(comp_row), .lvl(lvl),
         .out_l_push(l_push[i]), .out_l_data(l_din[i]),
         .out_r_push(r_push[i]), .out_r_data(r_din[i]),
         .in_l_empty(r_empty[IL]), .in_l_data(r_dout[IL]), .in_l_pop(r_pop[IL]),
         .in_r_empty(l_empty[IR]), .in_r_data(l_dout[IR]), .in_r_pop(l_pop[IR]),
         .rx_done(rx_done[i]),
         .rd_lvl(rd_level), .rd_row(rd_loc), .rd_val(rd_vals[i])
      );
   end

   always_comb begin
      rd_data = '0;
      if (int'(rd_pe) < NPE) rd_data = rd_vals[rd_pe];
   end

endmodule

// File: tb/band_power_engine_tb_top.sv
module band_power_engine_tb_top;
   localparam int NPE = 4, ROWS_PE = 4, BW = 5, MAXK = 8, DW = 16, FRAC = 8;
   localparam int N = NPE * ROWS_PE, H = (BW - 1) / 2;
   localparam int RW = $clog2(N), KW = $clog2(MAXK + 1), DGW = $clog2(BW);

   logic clk = 0, rst_n = 0;
   logic ld_en = 0, ld_vec = 0, start = 0;
   logic [RW-1:0] ld_row = '0, rd_row = '0;
   logic [DGW-1:0] ld_diag = '0;
   logic [DW-1:0] ld_data = '0;
   logic [KW-1:0] k_in = '0, rd_level = '0;
   logic busy, done;
   logic [DW-1:0] rd_data;

   always #10 clk = ~clk;

   band_power_engine #(.NPE(NPE), .ROWS_PE(ROWS_PE), .BW(BW), .MAXK(MAXK),
                       .DW(DW), .FRAC(FRAC)) dut_i (
      .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_vec(ld_vec), .ld_row(ld_row),
      .ld_diag(ld_diag), .ld_data(ld_data), .start(start), .k_in(k_in),
      .busy(busy), .done(done), .rd_level(rd_level), .rd_row(rd_row),
      .rd_data(rd_data));

   int n_chk = 0, n_fail = 0;
   int amat [N][BW];
   int xv   [N];
   int refv [MAXK+1][N];
   int seed = 7;
   bit finished = 0;

   task automatic chk(input string req, input int got, input int exp);
      n_chk++;
      if (got != exp) begin
         n_fail++;
         $display("FAIL %s: got %0d expected %0d", req, got, exp);
      end
   endtask

   function automatic int rnd(input int lo, input int hi);
      seed = seed * 1103515245 + 12345;
      return lo + ((seed >>> 8) & 32'h7fff) % (hi - lo + 1);
   endfunction

   function automatic int sat16(input longint v);
      if (v > 32767) return 32767;
      if (v < -32768) return -32768;
      return int'(v);
   endfunction

   // reference products from R1, R2, R3, R4
   task automatic ref_run(input int k);
      for (int i = 0; i < N; i++) refv[0][i] = xv[i];
      for (int l = 1; l <= k; l++)
         for (int i = 0; i < N; i++) begin
            longint acc = 0;
            for (int d = 0; d < BW; d++) begin
               int c = i + d - H;
               if (c >= 0 && c < N) acc += longint'(amat[i][d]) * longint'(refv[l-1][c]);
            end
            refv[l][i] = sat16(acc >>> FRAC);
         end
   endtask

   task automatic load_all();
      for (int i = 0; i < N; i++) begin
         for (int d = 0; d < BW; d++) begin
            @(negedge clk);
            ld_en = 1; ld_vec = 0; ld_row = RW'(i); ld_diag = DGW'(d); ld_data = DW'(amat[i][d]);
         end
         @(negedge clk);
         ld_en = 1; ld_vec = 1; ld_row = RW'(i); ld_data = DW'(xv[i]);
      end
      @(negedge clk);
      ld_en = 0;
   endtask

   task automatic run_k(input int k, input string req, output int cyc);
      @(negedge clk); start = 1; k_in = KW'(k);
      @(negedge clk); start = 0; cyc = 1;
      while (!done && cyc < 5000) begin @(negedge clk); cyc++; end
      chk({req, " done seen"}, int'(done), 1);
      chk("R6 busy high with done", int'(busy), 1);
      @(negedge clk);
      chk("R6 done lasts one cycle", int'(done), 0);
      chk("R6 busy low after done", int'(busy), 0);
   endtask

   task automatic check_levels(input int k, input string req);
      for (int l = 1; l <= k; l++)
         for (int i = 0; i < N; i++) begin
            rd_level = KW'(l); rd_row = RW'(i); #1;
            chk(req, int'($signed(rd_data)), refv[l][i]);
         end
   endtask

   task automatic clear_mat();
      for (int i = 0; i < N; i++) begin
         for (int d = 0; d < BW; d++) amat[i][d] = 0;
         xv[i] = 0;
      end
   endtask

   task automatic t_reset();
      chk("R6 busy after reset", int'(busy), 0);
      chk("R6 done after reset", int'(done), 0);
   endtask

   task automatic t_identity();
      int cyc;
      clear_mat();
      for (int i = 0; i < N; i++) begin amat[i][H] = 256; xv[i] = 100 * i - 700; end
      for (int i = 0; i < N; i++) amat[i][0] = 999 * (i < H ? 1 : 0);
      load_all(); ref_run(3); run_k(3, "R1 identity", cyc);
      check_levels(3, "R1 R2 identity levels");
   endtask

   task automatic t_shift();
      int cyc;
      clear_mat();
      for (int i = 0; i < N; i++) begin amat[i][H+1] = 256; xv[i] = i + 1; end
      amat[N-1][BW-1] = 1234;
      load_all(); ref_run(5); run_k(5, "R5 shift up", cyc);
      check_levels(5, "R4 R5 shift up levels");
      rd_level = 3; rd_row = 14; #1; chk("R4 past end reads zero", int'($signed(rd_data)), 0);
      rd_row = 2; #1; chk("R5 boundary shift value", int'($signed(rd_data)), 6);
      clear_mat();
      for (int i = 0; i < N; i++) begin amat[i][0] = 256; xv[i] = 10 * i + 5; end
      amat[0][1] = 777;
      load_all(); ref_run(4); run_k(4, "R5 shift down", cyc);
      check_levels(4, "R4 R5 shift down levels");
      rd_level = 1; rd_row = 4; #1; chk("R5 halo from left element", int'($signed(rd_data)), 25);
   endtask

   task automatic t_random();
      int cyc;
      for (int i = 0; i < N; i++) begin
         for (int d = 0; d < BW; d++) amat[i][d] = rnd(-200, 200);
         xv[i] = rnd(-3000, 3000);
      end
      load_all(); ref_run(MAXK); run_k(MAXK, "R2 random", cyc);
      check_levels(MAXK, "R2 R5 random band levels");
   endtask

   task automatic t_saturate();
      int cyc;
      clear_mat();
      for (int i = 0; i < N; i++) begin
         amat[i][H] = 512;
         xv[i] = (i % 4 == 0) ? 30000 : (i % 4 == 1) ? -30000 : (i % 4 == 2) ? 100 : -100;
      end
      load_all(); ref_run(2); run_k(2, "R3 saturate", cyc);
      check_levels(2, "R3 saturation levels");
      rd_level = 1; rd_row = 0; #1; chk("R3 upper clamp", int'($signed(rd_data)), 32767);
      rd_row = 1; #1; chk("R3 lower clamp", int'($signed(rd_data)), -32768);
   endtask

   task automatic t_kclamp();
      int c0, c1, c8, c15;
      run_k(1, "R7 k=1", c1);
      run_k(0, "R7 k=0", c0);
      chk("R7 k=0 runs like k=1", c0, c1);
      ref_run(1); check_levels(1, "R7 k=0 level");
      run_k(MAXK, "R7 k=MAXK", c8);
      run_k(15, "R7 k above MAXK", c15);
      chk("R7 k=15 runs like MAXK", c15, c8);
      ref_run(MAXK); check_levels(MAXK, "R7 R9 clamped levels");
   endtask

   task automatic t_busy_start();
      int c2, cyc, extra;
      run_k(2, "R8 baseline", c2);
      @(negedge clk); start = 1; k_in = 2;
      @(negedge clk); start = 0; cyc = 1;
      repeat (3) begin @(negedge clk); cyc++; end
      start = 1; k_in = KW'(MAXK);
      @(negedge clk); start = 0; cyc++;
      while (!done && cyc < 5000) begin @(negedge clk); cyc++; end
      chk("R8 run length unchanged", cyc, c2);
      extra = 0;
      repeat (200) begin @(negedge clk); if (done) extra++; end
      chk("R8 no second done", extra, 0);
      ref_run(2); check_levels(2, "R8 R9 results after ignored start");
   endtask

   initial begin
      #(20 * 150000);
      if (!finished) begin
         n_fail++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      t_reset();
      t_identity();
      t_shift();
      t_random();
      t_saturate();
      t_random();
      t_kclamp();
      t_busy_start();
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end
endmodule